// File: doc/BRIEF.md
# CAN Message Acceptance Filter

This block sits behind a CAN receiver and decides, one frame at a time, which of fifteen message objects a received frame belongs to. Each frame arrives as a single-cycle strobe carrying its identifier, a standard/extended flag, a remote/data flag, a length code and eight data bytes. One cycle later the block either emits a store strobe with the winning object index and the frame payload, or an automatic-reply request for a transmit object, or nothing.

Identifiers first pass a global mask. There is one mask for 11-bit identifiers and another for 29-bit identifiers. They are then compared against objects 1 to 14, and the lowest-numbered match wins. Only when none of those match is the last object tried. That object is receive-only, applies an additional local mask so it can collect a whole group of identifiers, and can hold two frames that the host has not yet released.

A small register port sets up the masks and the per-object identifier and control bits. The same port issues host transmit commands and reads and clears per-object receive and transmit flags.

Top module: `can_accept_filter`

## Requirements
- R1: After reset all outputs are 0, every object is invalid with identifier 0, both global masks and the local mask read as all ones, and all status flags and the last object's occupancy are 0.
- R2: A mask bit of 1 forces that identifier bit to match and a 0 makes it don't-care. Standard frames use the 11-bit standard mask on identifier bits 10:0 only, and bits 28:11 of a standard frame are ignored. Extended frames use the 29-bit extended mask.
- R3: An object takes part in matching only when its valid bit is set and its extended bit equals the frame's extended flag.
- R4: When several of objects 1 to 14 match, the lowest-numbered one is selected.
- R5: The last object (15) is tried only when objects 1 to 14 all miss, and it compares under the global mask ANDed with its local mask.
- R6: A data frame (remote flag 0) matches only receive-direction objects. A match gives st_vld one cycle later with st_idx, st_dlc and st_data equal to the object index and the frame's length and data, and it sets the object's receive flag. With no match all outputs stay 0.
- R7: A remote frame (remote flag 1) matches only transmit-direction objects among 1 to 14. A match gives ar_vld and ar_idx one cycle later and sets the object's transmit flag, with no store strobe.
- R8: Object 15 is receive-only: its direction bit reads back 0 whatever is written.
- R9: Object 15 counts stored-but-unreleased frames up to 2. Writing 1 to status bit 2 of object 15 releases one frame, and a release at 0 is ignored. A frame won by object 15 while 2 are held is dropped with no strobe.
- R10: Writing 1 to bit 0 of an object's command field (field 3) gives tx_vld and tx_idx one cycle later if the object is valid. tx_rmt is 1 for a receive-direction object (a remote request) and 0 for a transmit-direction object. The command also sets the transmit flag. Commands to invalid objects do nothing.
- R11: The status field (field 2) reads bit 0 receive flag, bit 1 transmit flag and, for object 15, bits 3:2 occupancy. Writing 1 to bit 0 or bit 1 clears that flag, and a set in the same cycle wins over a clear.
- R12: cfg_addr is {object[5:2], field[1:0]}. Object 0 fields 0, 1 and 2 are the standard, extended and local masks. For objects 1 to 15, field 0 is the identifier and field 1 the control bits {valid[2], transmit direction[1], extended[0]}. cfg_rdata returns the addressed value one cycle after cfg_re and 0 otherwise. A write takes effect for frames in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Received frame strobe |
| frm_id | input | 29 | Frame identifier (standard frames use bits 10:0) |
| frm_ext | input | 1 | 1 = extended identifier |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes |
| cfg_we | input | 1 | Register write |
| cfg_re | input | 1 | Register read |
| cfg_addr | input | 6 | {object, field} |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_re |
| st_vld | output | 1 | Store strobe |
| st_idx | output | 4 | Object receiving the frame |
| st_dlc | output | 4 | Stored length code |
| st_data | output | 64 | Stored data bytes |
| ar_vld | output | 1 | Automatic data-frame reply request |
| ar_idx | output | 4 | Object to reply from |
| tx_vld | output | 1 | Host transmit request |
| tx_idx | output | 4 | Object to transmit |
| tx_rmt | output | 1 | 1 = send a remote frame |

## Verification
The assertions take frame strobes to be single-cycle events whose remote flag is meaningful only while frm_valid is high. They also take the occupancy of the last object to move only through stores and releases. The bench drives every frame as one-cycle pulse, sets the flags at the falling edge, and clears them again after one clock. Register traffic is allowed in the same cycle as a frame, because the reference model matches against the old configuration and applies writes, clears and then sets in the order the requirements give. The random phase draws identifiers from a small pool that hits overlapping objects, the group object and the full-buffer case.

// File: rtl/can_af_pkg.sv
`timescale 1ns/1ps
package can_af_pkg;
  localparam logic [1:0] F_ID   = 2'd0;
  localparam logic [1:0] F_CTRL = 2'd1;
  localparam logic [1:0] F_STAT = 2'd2;
  localparam logic [1:0] F_CMD  = 2'd3;

  localparam int CB_EXT = 0;
  localparam int CB_DIR = 1;
  localparam int CB_VAL = 2;

  localparam int SB_RX  = 0;
  localparam int SB_TX  = 1;
  localparam int SB_REL = 2;

  typedef struct packed {
    logic valid;
    logic tx_dir;
    logic ext;
  } obj_ctrl_t;
endpackage

// File: rtl/can_af_regs.sv
`timescale 1ns/1ps
module can_af_regs
  import can_af_pkg::*;
#(
  parameter int NOBJ  = 15,
  parameter int IDX_W = 4,
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] obj,
  input  logic [1:0]       fld,
  input  logic [ID_W-1:0]  wdata,
  output logic [STD_W-1:0] std_mask,
  output logic [ID_W-1:0]  ext_mask,
  output logic [ID_W-1:0]  loc_mask,
  output logic [ID_W-1:0]  obj_id   [1:NOBJ],
  output obj_ctrl_t        obj_ctrl [1:NOBJ]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      std_mask <= '1;
      ext_mask <= '1;
      loc_mask <= '1;
    end else if (we && obj == '0) begin
      case (fld)
        F_ID:    std_mask <= wdata[STD_W-1:0];
        F_CTRL:  ext_mask <= wdata;
        F_STAT:  loc_mask <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 1; g <= NOBJ; g++) begin : g_obj
    logic [ID_W-1:0] id_q;
    obj_ctrl_t       ctl_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        id_q  <= '0;
        ctl_q <= '0;
      end else if (we && obj == IDX_W'(g)) begin
        if (fld == F_ID) id_q <= wdata;
        if (fld == F_CTRL) begin
          ctl_q.valid  <= wdata[CB_VAL];
          ctl_q.tx_dir <= (g == NOBJ) ? 1'b0 : wdata[CB_DIR];
          ctl_q.ext    <= wdata[CB_EXT];
        end
      end
    end
    assign obj_id[g]   = id_q;
    assign obj_ctrl[g] = ctl_q;
  end
endmodule

// File: rtl/can_af_match.sv
`timescale 1ns/1ps
module can_af_match
  import can_af_pkg::*;
#(
  parameter int NOBJ  = 15,
  parameter int IDX_W = 4,
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic [ID_W-1:0]  frm_id,
  input  logic             frm_ext,
  input  logic             frm_rtr,
  input  logic [STD_W-1:0] std_mask,
  input  logic [ID_W-1:0]  ext_mask,
  input  logic [ID_W-1:0]  loc_mask,
  input  logic [ID_W-1:0]  obj_id   [1:NOBJ],
  input  obj_ctrl_t        obj_ctrl [1:NOBJ],
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [ID_W-1:0] eff_mask;
  logic [NOBJ:1]   cand;

  assign eff_mask = frm_ext ? ext_mask : ID_W'(std_mask);

  for (genvar g = 1; g < NOBJ; g++) begin : g_cmp
    assign cand[g] = obj_ctrl[g].valid && (obj_ctrl[g].ext == frm_ext) &&
                     (obj_ctrl[g].tx_dir == frm_rtr) &&
                     (((frm_id ^ obj_id[g]) & eff_mask) == '0);
  end

  assign cand[NOBJ] = obj_ctrl[NOBJ].valid && (obj_ctrl[NOBJ].ext == frm_ext) &&
                      !obj_ctrl[NOBJ].tx_dir && !frm_rtr &&
                      (((frm_id ^ obj_id[NOBJ]) & eff_mask & loc_mask) == '0);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NOBJ - 1; i >= 1; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
    if (!hit && cand[NOBJ]) begin
      hit = 1'b1;
      idx = IDX_W'(NOBJ);
    end
  end
endmodule

// File: rtl/can_af_status.sv
`timescale 1ns/1ps
module can_af_status #(
  parameter int NOBJ      = 15,
  parameter int IDX_W     = 4,
  parameter int BUF_DEPTH = 2,
  parameter int OCC_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_rx,
  input  logic [IDX_W-1:0] rx_idx,
  input  logic             set_tx_a,
  input  logic [IDX_W-1:0] tx_a_idx,
  input  logic             set_tx_b,
  input  logic [IDX_W-1:0] tx_b_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_rx,
  input  logic             clr_tx,
  input  logic             push,
  input  logic             pop,
  output logic [NOBJ:1]    rx_flag,
  output logic [NOBJ:1]    tx_flag,
  output logic [OCC_W-1:0] occ,
  output logic             full
);
  for (genvar g = 1; g <= NOBJ; g++) begin : g_flag
    logic sel_clr;
    assign sel_clr = clr_en && clr_idx == IDX_W'(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        rx_flag[g] <= 1'b0;
        tx_flag[g] <= 1'b0;
      end else begin
        if (set_rx && rx_idx == IDX_W'(g))         rx_flag[g] <= 1'b1;
        else if (sel_clr && clr_rx)                rx_flag[g] <= 1'b0;
        if ((set_tx_a && tx_a_idx == IDX_W'(g)) ||
            (set_tx_b && tx_b_idx == IDX_W'(g)))   tx_flag[g] <= 1'b1;
        else if (sel_clr && clr_tx)                tx_flag[g] <= 1'b0;
      end
    end
  end

  logic dec;
  assign dec  = pop && occ != '0;
  assign full = occ == OCC_W'(BUF_DEPTH);

  always_ff @(posedge clk) begin
    if (rst)              occ <= '0;
    else if (push && !dec) occ <= occ + 1'b1;
    else if (!push && dec) occ <= occ - 1'b1;
  end
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter
  import can_af_pkg::*;
#(
  parameter int NOBJ      = 15,
  parameter int ID_W      = 29,
  parameter int STD_W     = 11,
  parameter int DATA_W    = 64,
  parameter int BUF_DEPTH = 2,
  parameter int REG_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frm_valid,
  input  logic [ID_W-1:0]              frm_id,
  input  logic                         frm_ext,
  input  logic                         frm_rtr,
  input  logic [3:0]                   frm_dlc,
  input  logic [DATA_W-1:0]            frm_data,
  input  logic                         cfg_we,
  input  logic                         cfg_re,
  input  logic [$clog2(NOBJ+1)+1:0]    cfg_addr,
  input  logic [REG_W-1:0]             cfg_wdata,
  output logic [REG_W-1:0]             cfg_rdata,
  output logic                         st_vld,
  output logic [$clog2(NOBJ+1)-1:0]    st_idx,
  output logic [3:0]                   st_dlc,
  output logic [DATA_W-1:0]            st_data,
  output logic                         ar_vld,
  output logic [$clog2(NOBJ+1)-1:0]    ar_idx,
  output logic                         tx_vld,
  output logic [$clog2(NOBJ+1)-1:0]    tx_idx,
  output logic                         tx_rmt
);
  localparam int IDX_W = $clog2(NOBJ + 1);
  localparam int OCC_W = $clog2(BUF_DEPTH + 1);

  logic [IDX_W-1:0] a_obj;
  logic [1:0]       a_fld;
  assign a_obj = cfg_addr[IDX_W+1:2];
  assign a_fld = cfg_addr[1:0];

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[REG_W-1:ID_W];

  logic [STD_W-1:0] std_mask;
  logic [ID_W-1:0]  ext_mask, loc_mask;
  logic [ID_W-1:0]  obj_id   [1:NOBJ];
  obj_ctrl_t        obj_ctrl [1:NOBJ];

  can_af_regs #(.NOBJ(NOBJ), .IDX_W(IDX_W), .ID_W(ID_W), .STD_W(STD_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .obj(a_obj), .fld(a_fld),
    .wdata(cfg_wdata[ID_W-1:0]), .std_mask(std_mask), .ext_mask(ext_mask),
    .loc_mask(loc_mask), .obj_id(obj_id), .obj_ctrl(obj_ctrl)
  );

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;

  can_af_match #(.NOBJ(NOBJ), .IDX_W(IDX_W), .ID_W(ID_W), .STD_W(STD_W)) u_match (
    .frm_id(frm_id), .frm_ext(frm_ext), .frm_rtr(frm_rtr), .std_mask(std_mask),
    .ext_mask(ext_mask), .loc_mask(loc_mask), .obj_id(obj_id), .obj_ctrl(obj_ctrl),
    .hit(m_hit), .idx(m_idx)
  );

  // host command decode against the addressed object's current control bits
  logic obj_in_range, cmd_valid, cmd_dir;
  always_comb begin
    cmd_valid = 1'b0;
    cmd_dir   = 1'b0;
    for (int i = 1; i <= NOBJ; i++) begin
      if (a_obj == IDX_W'(i)) begin
        cmd_valid = obj_ctrl[i].valid;
        cmd_dir   = obj_ctrl[i].tx_dir;
      end
    end
  end
  assign obj_in_range = a_obj != '0 && a_obj <= IDX_W'(NOBJ);

  logic [NOBJ:1]    rx_flag, tx_flag;
  logic [OCC_W-1:0] occ;
  logic             full, to_last, store_go, reply_go, send_go, stat_wr, release_go;

  assign to_last    = m_idx == IDX_W'(NOBJ);
  assign store_go   = frm_valid && m_hit && !frm_rtr && !(to_last && full);
  assign reply_go   = frm_valid && m_hit && frm_rtr;
  assign send_go    = cfg_we && obj_in_range && a_fld == F_CMD && cfg_wdata[0] && cmd_valid;
  assign stat_wr    = cfg_we && obj_in_range && a_fld == F_STAT;
  assign release_go = stat_wr && a_obj == IDX_W'(NOBJ) && cfg_wdata[SB_REL];

  can_af_status #(.NOBJ(NOBJ), .IDX_W(IDX_W), .BUF_DEPTH(BUF_DEPTH), .OCC_W(OCC_W)) u_stat (
    .clk(clk), .rst(rst),
    .set_rx(store_go), .rx_idx(m_idx),
    .set_tx_a(reply_go), .tx_a_idx(m_idx),
    .set_tx_b(send_go), .tx_b_idx(a_obj),
    .clr_en(stat_wr), .clr_idx(a_obj), .clr_rx(cfg_wdata[SB_RX]), .clr_tx(cfg_wdata[SB_TX]),
    .push(store_go && to_last), .pop(release_go),
    .rx_flag(rx_flag), .tx_flag(tx_flag), .occ(occ), .full(full)
  );

  logic [REG_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (a_obj == '0) begin
      case (a_fld)
        F_ID:    rd_val[STD_W-1:0] = std_mask;
        F_CTRL:  rd_val[ID_W-1:0]  = ext_mask;
        F_STAT:  rd_val[ID_W-1:0]  = loc_mask;
        default: ;
      endcase
    end
    for (int i = 1; i <= NOBJ; i++) begin
      if (a_obj == IDX_W'(i)) begin
        case (a_fld)
          F_ID:   rd_val[ID_W-1:0] = obj_id[i];
          F_CTRL: rd_val[2:0]      = obj_ctrl[i];
          F_STAT: begin
            rd_val[SB_RX] = rx_flag[i];
            rd_val[SB_TX] = tx_flag[i];
            if (i == NOBJ) rd_val[OCC_W+1:2] = occ;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
      st_vld <= 1'b0; st_idx <= '0; st_dlc <= '0; st_data <= '0;
      ar_vld <= 1'b0; ar_idx <= '0;
      tx_vld <= 1'b0; tx_idx <= '0; tx_rmt <= 1'b0;
    end else begin
      cfg_rdata <= cfg_re ? rd_val : '0;
      st_vld  <= store_go;
      st_idx  <= store_go ? m_idx : '0;
      st_dlc  <= store_go ? frm_dlc : '0;
      st_data <= store_go ? frm_data : '0;
      ar_vld  <= reply_go;
      ar_idx  <= reply_go ? m_idx : '0;
      tx_vld  <= send_go;
      tx_idx  <= send_go ? a_obj : '0;
      tx_rmt  <= send_go && !cmd_dir;
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
`timescale 1ns/1ps
module can_accept_filter_chk #(
  parameter int NOBJ      = 15,
  parameter int IDX_W     = 4,
  parameter int BUF_DEPTH = 2,
  parameter int OCC_W     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_valid,
  input logic             frm_rtr,
  input logic             st_vld,
  input logic [IDX_W-1:0] st_idx,
  input logic             ar_vld,
  input logic [IDX_W-1:0] ar_idx,
  input logic             tx_vld,
  input logic [IDX_W-1:0] tx_idx,
  input logic [OCC_W-1:0] occ
);
  AST_STORE_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    st_vld |-> $past(frm_valid && !frm_rtr)); // R6
  AST_STORE_IDX_LEGAL: assert property (@(posedge clk) disable iff (rst)
    st_vld |-> (st_idx != '0 && st_idx <= IDX_W'(NOBJ))); // R6
  AST_REPLY_FROM_REMOTE: assert property (@(posedge clk) disable iff (rst)
    ar_vld |-> ($past(frm_valid && frm_rtr) && !st_vld)); // R7
  AST_LAST_NEVER_REPLIES: assert property (@(posedge clk) disable iff (rst)
    ar_vld |-> (ar_idx != '0 && ar_idx != IDX_W'(NOBJ))); // R8
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(BUF_DEPTH)); // R9
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (st_vld && st_idx == IDX_W'(NOBJ)) |-> $past(occ) < OCC_W'(BUF_DEPTH)); // R9
  AST_CMD_IDX_LEGAL: assert property (@(posedge clk) disable iff (rst)
    tx_vld |-> (tx_idx != '0 && tx_idx <= IDX_W'(NOBJ))); // R10
endmodule

bind can_accept_filter can_accept_filter_chk #(
  .NOBJ(NOBJ), .IDX_W(IDX_W), .BUF_DEPTH(BUF_DEPTH), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_rtr(frm_rtr),
  .st_vld(st_vld), .st_idx(st_idx), .ar_vld(ar_vld), .ar_idx(ar_idx),
  .tx_vld(tx_vld), .tx_idx(tx_idx), .occ(occ)
);

// File: tb/test_can_accept_filter.sv
`timescale 1ns/1ps
module test_can_accept_filter;
  localparam int NOBJ = 15;
  localparam int MID  = 32'h1FFF_FFFF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, frm_valid, frm_ext, frm_rtr, cfg_we, cfg_re;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        st_vld, ar_vld, tx_vld, tx_rmt;
  logic [3:0]  st_idx, ar_idx, tx_idx, st_dlc;
  logic [63:0] st_data;

  can_accept_filter i_can_accept_filter (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_id(frm_id), .frm_ext(frm_ext),
    .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data), .cfg_we(cfg_we),
    .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .st_vld(st_vld), .st_idx(st_idx), .st_dlc(st_dlc), .st_data(st_data),
    .ar_vld(ar_vld), .ar_idx(ar_idx), .tx_vld(tx_vld), .tx_idx(tx_idx), .tx_rmt(tx_rmt)
  );

  int checks = 0, errors = 0;

  // reference model state
  int m_id[16];
  bit m_val[16], m_dir[16], m_ext[16], m_rx[16], m_tx[16];
  int m_std, m_extm, m_loc, m_occ;
  // expected outputs
  bit e_st, e_ar, e_tx, e_rmt;
  int e_st_idx, e_ar_idx, e_tx_idx, e_dlc;
  logic [63:0] e_data;
  int e_rd;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_id[i] = 0; m_val[i] = 0; m_dir[i] = 0; m_ext[i] = 0; m_rx[i] = 0; m_tx[i] = 0;
    end
    m_std = 'h7FF; m_extm = MID; m_loc = MID; m_occ = 0;
  endtask

  function automatic int read_val(int obj, int fld);
    if (obj == 0) return (fld == 0) ? m_std : (fld == 1) ? m_extm : (fld == 2) ? m_loc : 0;
    if (fld == 0) return m_id[obj];
    if (fld == 1) return {29'd0, m_val[obj], m_dir[obj], m_ext[obj]};
    if (fld == 2) return (obj == NOBJ ? m_occ << 2 : 0) | (int'(m_tx[obj]) << 1) | int'(m_rx[obj]);
    return 0;
  endfunction

  task automatic model_eval();
    int obj, fld, win, em;
    bit set_rx, set_tx_f, set_tx_c, push, pop;
    obj = int'(cfg_addr[5:2]); fld = int'(cfg_addr[1:0]);
    e_st = 0; e_ar = 0; e_tx = 0; e_rmt = 0;
    e_st_idx = 0; e_ar_idx = 0; e_tx_idx = 0; e_dlc = 0; e_data = '0;
    set_rx = 0; set_tx_f = 0; set_tx_c = 0; push = 0; pop = 0; win = 0;
    if (frm_valid) begin
      em = frm_ext ? m_extm : m_std;
      for (int i = 1; i < NOBJ; i++)
        if (win == 0 && m_val[i] && m_ext[i] == frm_ext && m_dir[i] == frm_rtr &&
            ((int'(frm_id) ^ m_id[i]) & em) == 0) win = i;
      if (win == 0 && !frm_rtr && m_val[NOBJ] && m_ext[NOBJ] == frm_ext &&
          ((int'(frm_id) ^ m_id[NOBJ]) & em & m_loc) == 0) win = NOBJ;
      if (win != 0 && frm_rtr) begin
        e_ar = 1; e_ar_idx = win; set_tx_f = 1;
      end else if (win != 0 && !(win == NOBJ && m_occ == 2)) begin
        e_st = 1; e_st_idx = win; e_dlc = frm_dlc; e_data = frm_data; set_rx = 1;
        push = (win == NOBJ);
      end
    end
    e_rd = cfg_re ? read_val(obj, fld) : 0;
    if (cfg_we && obj >= 1 && fld == 3 && cfg_wdata[0] && m_val[obj]) begin
      e_tx = 1; e_tx_idx = obj; e_rmt = !m_dir[obj]; set_tx_c = 1;
    end
    if (cfg_we) begin
      if (obj == 0) begin
        if (fld == 0) m_std = cfg_wdata & 'h7FF;
        if (fld == 1) m_extm = cfg_wdata & MID;
        if (fld == 2) m_loc = cfg_wdata & MID;
      end else begin
        if (fld == 0) m_id[obj] = cfg_wdata & MID;
        if (fld == 1) begin
          m_val[obj] = cfg_wdata[2]; m_dir[obj] = (obj == NOBJ) ? 0 : cfg_wdata[1];
          m_ext[obj] = cfg_wdata[0];
        end
        if (fld == 2) begin
          if (cfg_wdata[0]) m_rx[obj] = 0;
          if (cfg_wdata[1]) m_tx[obj] = 0;
          if (obj == NOBJ && cfg_wdata[2] && m_occ > 0) pop = 1;
        end
      end
    end
    if (set_rx)   m_rx[win] = 1;
    if (set_tx_f) m_tx[win] = 1;
    if (set_tx_c) m_tx[obj] = 1;
    m_occ = m_occ + int'(push) - int'(pop);
  endtask

  task automatic step(string req);
    model_eval();
    @(posedge clk);
    @(negedge clk);
    chk(req, "st_vld", st_vld, e_st);
    chk(req, "st_idx", st_idx, e_st_idx);
    chk(req, "st_dlc", st_dlc, e_dlc);
    chk(req, "st_data", st_data, e_data);
    chk(req, "ar_vld", ar_vld, e_ar);
    chk(req, "ar_idx", ar_idx, e_ar_idx);
    chk(req, "tx_vld", tx_vld, e_tx);
    chk(req, "tx_idx", tx_idx, e_tx_idx);
    chk(req, "tx_rmt", tx_rmt, e_rmt);
    chk(req, "cfg_rdata", cfg_rdata, e_rd);
    frm_valid = 0; cfg_we = 0; cfg_re = 0;
  endtask

  task automatic set_frame(int id, bit ext, bit rtr);
    frm_valid = 1; frm_id = 29'(id); frm_ext = ext; frm_rtr = rtr;
    frm_dlc = 4'(id % 9); frm_data = {32'(id) ^ 32'hA5A5_0000, ~32'(id)};
  endtask

  task automatic frame(int id, bit ext, bit rtr, string req);
    set_frame(id, ext, rtr);
    step(req);
  endtask

  task automatic wr(int obj, int fld, int data, string req);
    cfg_we = 1; cfg_addr = {4'(obj), 2'(fld)}; cfg_wdata = data;
    step(req);
  endtask

  task automatic rd(int obj, int fld, string req);
    cfg_re = 1; cfg_addr = {4'(obj), 2'(fld)};
    step(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; frm_valid = 0; frm_id = '0; frm_ext = 0; frm_rtr = 0; frm_dlc = '0;
    frm_data = '0; cfg_we = 0; cfg_re = 0; cfg_addr = '0; cfg_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    step("R1");
    rd(0, 0, "R1"); rd(0, 1, "R1"); rd(0, 2, "R1"); rd(3, 1, "R1"); rd(15, 2, "R1");

    // configuration through the register map
    wr(0, 0, 'h7F0, "R12");          // low 4 standard bits don't-care
    wr(1, 0, 'h120, "R12"); wr(1, 1, 'b100, "R12");
    wr(2, 0, 'h123, "R12"); wr(2, 1, 'b100, "R12");
    wr(3, 0, 'h1ABCDEF, "R12"); wr(3, 1, 'b101, "R12");
    wr(4, 0, 'h200, "R12"); wr(4, 1, 'b110, "R12");
    wr(15, 0, 'h300, "R12"); wr(0, 2, 'h700, "R12");
    wr(15, 1, 'b110, "R8");          // direction bit must be forced to 0
    rd(15, 1, "R8"); rd(1, 0, "R12"); rd(0, 0, "R12");

    frame('h125, 0, 0, "R4");        // objects 1 and 2 both match, 1 wins
    frame('h123, 0, 0, "R4");
    frame('h1FFFF920, 0, 0, "R2");   // upper bits ignored for standard frames
    frame('h130, 0, 0, "R2");        // masked bit differs: no match
    frame('h1ABCDEF, 1, 0, "R3");    // extended object
    frame('h120, 1, 0, "R3");        // extended frame does not hit standard objects
    frame('h1ABCDEE, 1, 0, "R2");    // full extended mask
    frame('h3AB, 0, 0, "R5");        // group object
    frame('h400, 0, 0, "R5");        // outside local group
    rd(15, 2, "R9");
    frame('h3CD, 0, 0, "R9");        // second held frame
    frame('h3EF, 0, 0, "R9");        // dropped, buffer full
    rd(15, 2, "R9");
    wr(15, 2, 'b100, "R9");          // release one
    frame('h3EF, 0, 0, "R9");
    wr(15, 2, 'b100, "R9"); wr(15, 2, 'b100, "R9"); wr(15, 2, 'b100, "R9");
    rd(15, 2, "R9");

    frame('h200, 0, 1, "R7");        // remote to transmit object
    frame('h120, 0, 1, "R7");        // remote to receive object: ignored
    frame('h3AB, 0, 1, "R7");        // remote never reaches the group object
    frame('h200, 0, 0, "R6");        // data to transmit object: ignored
    rd(4, 2, "R7");

    wr(1, 3, 1, "R10");              // receive object: remote request
    wr(4, 3, 1, "R10");              // transmit object: data frame
    wr(5, 3, 1, "R10");              // invalid object: nothing
    rd(5, 2, "R10");

    rd(1, 2, "R11");
    wr(1, 2, 'b01, "R11");
    rd(1, 2, "R11");
    set_frame('h121, 0, 0);          // set and clear of object 1 in one cycle
    cfg_we = 1; cfg_addr = {4'd1, 2'd2}; cfg_wdata = 'b11;
    step("R11");
    rd(1, 2, "R11");

    wr(1, 1, 'b000, "R3");           // invalidate object 1
    frame('h125, 0, 0, "R3");        // now object 2 wins

    for (int n = 0; n < 400; n++) begin
      int pool[8] = '{'h120, 'h12F, 'h123, 'h200, 'h3AB, 'h350, 'h1ABCDEF, 'h555};
      int r;
      r = int'($urandom % 8);
      set_frame(pool[r], (r == 6) ? 1'b1 : 1'($urandom % 5 == 0), 1'($urandom % 4 == 0));
      r = int'($urandom % 6);
      if (r == 0) begin cfg_we = 1; cfg_addr = {4'd15, 2'd2}; cfg_wdata = 'b111; end
      else if (r == 1) begin cfg_re = 1; cfg_addr = {4'(1 + $urandom % 15), 2'd2}; end
      else if (r == 2) begin cfg_we = 1; cfg_addr = {4'(1 + $urandom % 15), 2'd3}; cfg_wdata = 1; end
      step("R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule